// File: doc/BRIEF.md
# Four-Way Event Fragment Merger

This block collects one framed fragment for the same event from each of four input FIFOs and forwards them as a single larger fragment. The output begins with a header word that the block generates itself, carries the four input fragments whole and in fixed order (input 1 first, input 4 last), and ends with a trailer word that the block also generates. Each input fragment runs from its own header word to its own trailer word, and every word of it, including its header and trailer, is passed through unchanged. The last word of each input fragment is marked by a flag on that input.

Each input is a show-ahead FIFO port with valid/ready, so its head word is visible before it is popped. The block waits until all four inputs show a head word. It then reads the bunch counter field (the low 8 bits) of all four input headers at once. The counter from input 1 goes into the merger header. Each other input's counter is compared with input 1's, giving one error bit per input for the merger trailer. The trailer also holds the number of words forwarded between the merger header and the merger trailer. The output is a FIFO-style valid/ready port with flags marking the merger header and the merger trailer.

Top module: `frag_merger`

## Requirements
- R1: After reset, `outValid` is 0 and no `inReady` bit is set until an event starts.
- R2: No output word is offered and no input word is consumed until all four inputs show a head word at the same time.
- R3: The first word of each merged fragment has `outFirst`=1 and `outLast`=0. Bits [31:28] hold 4'hB, bits [7:0] hold bits [7:0] of input 1's header word, and all other bits are 0.
- R4: After the merger header, the words of input 1, then input 2, then input 3, then input 4 are forwarded bit-for-bit. Each input is forwarded from its head word up to and including the word flagged by its `inLast` bit, with `outFirst`=`outLast`=0 on every one of these words.
- R5: At most one `inReady` bit is set in any cycle. A bit is set only while `outReady` is 1, so only the input being forwarded is ever popped.
- R6: The last word of each merged fragment has `outLast`=1 and `outFirst`=0, with bits [31:28] = 4'hE. Bit 16+i (i = 0..3) is 1 exactly when bits [7:0] of input i+1's header differ from those of input 1's header, so bit 16 is always 0.
- R7: Bits [15:0] of the merger trailer equal the number of words forwarded between the merger header and the merger trailer. Bits [27:20] of the trailer are 0.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 4 | Per-input head word present |
| inReady | output | 4 | Per-input pop strobe |
| inData | input | 4 x 32 | Per-input head word |
| inLast | input | 4 | Per-input head word is that fragment's trailer |
| outValid | output | 1 | Output word present |
| outReady | input | 1 | Downstream accepts the output word |
| outData | output | 32 | Output word |
| outFirst | output | 1 | Output word is the merger header |
| outLast | output | 1 | Output word is the merger trailer |

## Verification
The bench builds the block with its default parameters: four inputs, 32-bit words, an 8-bit bunch counter and a 16-bit word count. This places every trailer field at the bit positions the requirements name. With these values the bench can reach fragments that are only a header and a trailer, a mismatch on a single input and on every input, and several events queued back to back. It also holds one input empty while the other three wait, and runs the merge under both downstream stalls and gaps in the input words.

// File: rtl/merge_pkg.sv
package merge_pkg;

  localparam int TAG_W = 4;
  localparam logic [TAG_W-1:0] HDR_TAG = 4'hB;
  localparam logic [TAG_W-1:0] TRL_TAG = 4'hE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_BODY,
    ST_TRL
  } mergeState_e;

  typedef enum logic [1:0] {
    SRC_BODY,
    SRC_HDR,
    SRC_TRL
  } outSrc_e;

  typedef struct packed {
    logic    capture;
    logic    countInc;
    outSrc_e src;
  } mergeStrobe_t;

endpackage

// File: rtl/merge_ctrl.sv
module merge_ctrl
  import merge_pkg::*;
#(
  parameter int NUM_IN = 4,
  localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] inValid,
  input  logic [NUM_IN-1:0] inLast,
  input  logic              outReady,
  output logic [NUM_IN-1:0] inReady,
  output logic              outValid,
  output logic              outFirst,
  output logic              outLast,
  output logic [SEL_W-1:0]  sel,
  output mergeStrobe_t      strobe
);

  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_IN - 1);

  mergeState_e state, stateNext;
  logic [SEL_W-1:0] selNext;
  logic allValid;

  assign allValid = &inValid;

  always_comb begin
    stateNext = state;
    selNext   = sel;
    inReady   = '0;
    outValid  = 1'b0;
    outFirst  = 1'b0;
    outLast   = 1'b0;
    strobe.capture  = 1'b0;
    strobe.countInc = 1'b0;
    strobe.src      = SRC_BODY;
    unique case (state)
      ST_IDLE: begin
        if (allValid) begin
          strobe.capture = 1'b1;
          stateNext = ST_HDR;
        end
      end
      ST_HDR: begin
        outValid   = 1'b1;
        outFirst   = 1'b1;
        strobe.src = SRC_HDR;
        if (outReady) begin
          stateNext = ST_BODY;
          selNext   = '0;
        end
      end
      ST_BODY: begin
        outValid     = inValid[sel];
        inReady[sel] = outReady;
        if (inValid[sel] && outReady) begin
          strobe.countInc = 1'b1;
          if (inLast[sel]) begin
            if (sel == LAST_SEL) stateNext = ST_TRL;
            else selNext = sel + 1'b1;
          end
        end
      end
      ST_TRL: begin
        outValid   = 1'b1;
        outLast    = 1'b1;
        strobe.src = SRC_TRL;
        if (outReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      sel   <= '0;
    end else begin
      state <= stateNext;
      sel   <= selNext;
    end
  end

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(inReady)); // R5
  AST_WAIT_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !allValid) |=> (!outValid && inReady == '0)); // R2
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid); // R8
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(outFirst && outLast)); // R3

endmodule

// File: rtl/merge_dpath.sv
module merge_dpath
  import merge_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int DATA_W  = 32,
  parameter int BC_W    = 8,
  parameter int COUNT_W = 16,
  localparam int SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_IN-1:0][DATA_W-1:0]  inData,
  input  logic [SEL_W-1:0]               sel,
  input  mergeStrobe_t                   strobe,
  input  logic                           outValid,
  input  logic                           outReady,
  input  logic                           outFirst,
  input  logic                           outLast,
  output logic [DATA_W-1:0]              outData
);

  logic [BC_W-1:0]    bcRef;
  logic [NUM_IN-1:0]  errBits;
  logic [NUM_IN-1:0]  errNow;
  logic [COUNT_W-1:0] wordCnt;

  for (genvar g = 0; g < NUM_IN; g++) begin : gCmp
    assign errNow[g] = (inData[g][BC_W-1:0] != inData[0][BC_W-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcRef   <= '0;
      errBits <= '0;
      wordCnt <= '0;
    end else if (strobe.capture) begin
      bcRef   <= inData[0][BC_W-1:0];
      errBits <= errNow;
      wordCnt <= '0;
    end else if (strobe.countInc) begin
      wordCnt <= wordCnt + 1'b1;
    end
  end

  always_comb begin
    outData = '0;
    unique case (strobe.src)
      SRC_HDR: begin
        outData[DATA_W-1 -: TAG_W] = HDR_TAG;
        outData[BC_W-1:0]          = bcRef;
      end
      SRC_TRL: begin
        outData[DATA_W-1 -: TAG_W]  = TRL_TAG;
        outData[COUNT_W +: NUM_IN]  = errBits;
        outData[COUNT_W-1:0]        = wordCnt;
      end
      default: outData = inData[sel];
    endcase
  end

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData)); // R8
  AST_SELF_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> !outData[COUNT_W]); // R6
  AST_CNT_AT_HDR: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFirst) |-> (wordCnt == '0)); // R7

endmodule

// File: rtl/frag_merger.sv
module frag_merger
  import merge_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int DATA_W  = 32,
  parameter int BC_W    = 8,
  parameter int COUNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_IN-1:0]             inValid,
  output logic [NUM_IN-1:0]             inReady,
  input  logic [NUM_IN-1:0][DATA_W-1:0] inData,
  input  logic [NUM_IN-1:0]             inLast,
  output logic                          outValid,
  input  logic                          outReady,
  output logic [DATA_W-1:0]             outData,
  output logic                          outFirst,
  output logic                          outLast
);

  localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [SEL_W-1:0] sel;
  mergeStrobe_t     strobe;

  initial begin
    AST_LAYOUT_FITS: assert (DATA_W >= COUNT_W + NUM_IN + TAG_W && DATA_W >= BC_W + TAG_W); // R6
  end

  merge_ctrl #(.NUM_IN(NUM_IN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .outFirst (outFirst),
    .outLast  (outLast),
    .sel      (sel),
    .strobe   (strobe)
  );

  merge_dpath #(
    .NUM_IN  (NUM_IN),
    .DATA_W  (DATA_W),
    .BC_W    (BC_W),
    .COUNT_W (COUNT_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .sel      (sel),
    .strobe   (strobe),
    .outValid (outValid),
    .outReady (outReady),
    .outFirst (outFirst),
    .outLast  (outLast),
    .outData  (outData)
  );

endmodule

// File: tb/frag_merger_tb.sv
module frag_merger_tb;

  localparam int NUM_IN  = 4;
  localparam int DATA_W  = 32;
  localparam int BC_W    = 8;
  localparam int COUNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_IN-1:0]             inValid = '0;
  logic [NUM_IN-1:0]             inReady;
  logic [NUM_IN-1:0][DATA_W-1:0] inData = '0;
  logic [NUM_IN-1:0]             inLast = '0;
  logic                          outValid;
  logic                          outReady = 1'b0;
  logic [DATA_W-1:0]             outData;
  logic                          outFirst;
  logic                          outLast;

  always #2 clk = ~clk;

  frag_merger #(.NUM_IN(NUM_IN), .DATA_W(DATA_W), .BC_W(BC_W), .COUNT_W(COUNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .outValid(outValid), .outReady(outReady), .outData(outData),
    .outFirst(outFirst), .outLast(outLast)
  );

  int errors = 0;
  int checks = 0;
  logic [DATA_W:0]   inQ [NUM_IN][$];
  logic [DATA_W+1:0] expQ[$];
  logic [NUM_IN-1:0] popPend = '0;
  logic [NUM_IN-1:0] enIn = '1;
  int hold [NUM_IN];
  int gapLen = 0;
  bit stallMode = 1'b0;
  int cyc = 0;
  int evtNo = 0;
  bit sawActivity = 1'b0;
  bit prevStall = 1'b0;
  logic [DATA_W-1:0] prevData = '0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [DATA_W+1:0] act,
                       input logic [DATA_W+1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: queue one event on the inputs and its expected merged output.
  task automatic pushEvent(input logic [BC_W-1:0] b0, input logic [BC_W-1:0] b1,
                           input logic [BC_W-1:0] b2, input logic [BC_W-1:0] b3,
                           input int l0, input int l1, input int l2, input int l3);
    logic [BC_W-1:0] bcs [NUM_IN];
    int lens [NUM_IN];
    logic [DATA_W-1:0] w;
    logic [NUM_IN-1:0] err;
    int total;
    bcs[0] = b0; bcs[1] = b1; bcs[2] = b2; bcs[3] = b3;
    lens[0] = l0; lens[1] = l1; lens[2] = l2; lens[3] = l3;
    evtNo++;
    w = '0; w[31:28] = 4'hB; w[7:0] = b0;
    expQ.push_back({1'b1, 1'b0, w});
    total = 0;
    err = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      err[i] = (bcs[i] != b0);
      w = {4'h5, 4'(i), 16'(evtNo), bcs[i]};
      inQ[i].push_back({1'b0, w});
      expQ.push_back({2'b00, w});
      total++;
      for (int j = 0; j < lens[i]; j++) begin
        w = {4'hD, 4'(i), 8'(j), 16'(evtNo * 7 + j)};
        inQ[i].push_back({1'b0, w});
        expQ.push_back({2'b00, w});
        total++;
      end
      w = {4'h7, 4'(i), 8'(lens[i]), 16'hFFFF};
      inQ[i].push_back({1'b1, w});
      expQ.push_back({2'b00, w});
      total++;
    end
    w = '0; w[31:28] = 4'hE; w[19:16] = err; w[15:0] = 16'(total);
    expQ.push_back({1'b0, 1'b1, w});
  endtask

  // FIFO models, stimulus and scoreboard monitor: drive at negedge, sample 1 ns later.
  initial begin
    for (int i = 0; i < NUM_IN; i++) hold[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NUM_IN; i++) begin
        if (popPend[i]) begin
          void'(inQ[i].pop_front());
          hold[i] = gapLen;
        end else if (hold[i] > 0) begin
          hold[i]--;
        end
        if (inQ[i].size() > 0 && hold[i] == 0 && enIn[i]) begin
          inValid[i] = 1'b1;
          inLast[i]  = inQ[i][0][DATA_W];
          inData[i]  = inQ[i][0][DATA_W-1:0];
        end else begin
          inValid[i] = 1'b0;
          inLast[i]  = 1'b0;
          inData[i]  = '0;
        end
      end
      popPend = '0;
      outReady = stallMode ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (rstN) begin
        // R5: one pop at a time, only with downstream ready
        check($countones(inReady) <= 1 && (inReady == '0 || outReady), "R5",
              {2'b00, 28'(0), inReady}, '0);
        if (prevStall)  // R8
          check(outValid && outData == prevData, "R8", {1'b0, outValid, outData},
                {2'b01, prevData});
        prevStall = outValid && !outReady;
        prevData  = outData;
        if (outValid || inReady != '0) sawActivity = 1'b1;
        for (int i = 0; i < NUM_IN; i++)
          if (inValid[i] && inReady[i]) popPend[i] = 1'b1;
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R4", {outFirst, outLast, outData}, '0);
          end else begin
            logic [DATA_W+1:0] e;
            e = expQ.pop_front();
            if (e[DATA_W+1])
              check({outFirst, outLast, outData} == e, "R3", {outFirst, outLast, outData}, e);
            else if (e[DATA_W])
              check({outFirst, outLast, outData} == e, "R6/R7", {outFirst, outLast, outData}, e);
            else
              check({outFirst, outLast, outData} == e, "R4", {outFirst, outLast, outData}, e);
          end
        end
      end
      cyc++;
    end
  end

  task automatic drain();
    while (expQ.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: idle after reset
    check(!outValid && inReady == '0, "R1", {1'b0, outValid, 26'(0), inReady}, '0);
    repeat (3) @(posedge clk);
    #1;
    check(!outValid && inReady == '0, "R1", {1'b0, outValid, 26'(0), inReady}, '0);

    // R3 R4 R6 R7: matching counters, one empty-payload input
    pushEvent(8'h12, 8'h12, 8'h12, 8'h12, 2, 0, 3, 1);
    drain();

    // R6: mismatch on input 3 only, downstream stalls (R8)
    stallMode = 1'b1;
    pushEvent(8'h40, 8'h40, 8'h41, 8'h40, 1, 1, 1, 1);
    drain();

    // R6: every other input mismatches, header+trailer-only fragments, input gaps
    gapLen = 2;
    pushEvent(8'hA5, 8'h00, 8'hFF, 8'h5A, 0, 0, 0, 0);
    drain();

    // R2: input 4 empty, nothing may move
    gapLen = 0;
    stallMode = 1'b0;
    enIn = 4'b0111;
    pushEvent(8'h07, 8'h07, 8'h08, 8'h07, 1, 2, 0, 1);
    repeat (3) @(posedge clk);
    sawActivity = 1'b0;
    repeat (20) @(posedge clk);
    check(!sawActivity, "R2", {1'b0, sawActivity, 32'h0}, '0);
    enIn = '1;
    drain();

    // R4: back-to-back events queued together, with stalls and gaps
    stallMode = 1'b1;
    gapLen = 1;
    pushEvent(8'h01, 8'h02, 8'h01, 8'h01, 3, 1, 2, 0);
    pushEvent(8'h33, 8'h33, 8'h33, 8'h34, 0, 4, 1, 2);
    drain();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule